// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block decides when the converter core and its bias generator of a serially controlled successive-approximation ADC are powered. It watches the 16-bit words that the serial port has already received, keeps the automatic power mode, the conversion timing and the static-shutdown selection, and turns chip-select, convert-start, software-convert and conversion-done events into two enables and a flag that marks conversions as valid.

With external-clock timing, the core goes to sleep when chip-select rises at the end of a frame, provided an automatic mode was in force when that frame opened. It wakes again when the next frame opens. With internal-clock timing, the core goes to sleep when the requested conversions finish. It wakes on a falling convert-start, or on a rising chip-select once a software convert has been requested. Auto-standby keeps the bias generator running while the core sleeps. A static shutdown overrides every automatic mode. Every wake is followed by a two-cycle warm-up, and no result is marked valid during it.

Top module: `adc_pwr_seq`

## Requirements
- R1: A received word with bit 15 = 0 writes the mode register: bits [5:4] = power code, bit 6 = timing (0 external, 1 internal). A word with bits [15:11] = 10000 writes the configuration register: bit 9 = averaging enable, bits [1:0] = static code. Any other word with bit 15 = 1 changes nothing.
- R2: Power code 00 keeps the core awake. Code 01 (auto-shutdown) turns off core_en and bias_en while asleep. Code 10 (auto-standby) turns off core_en and keeps bias_en high while asleep. Code 11 behaves as 00.
- R3: With external timing and code 01 or 10, core_en falls one cycle after a chip-select rise, but only if chip-select fell while an automatic code was already held and no mode write came after that fall. core_en rises one cycle after the next chip-select fall.
- R4: After core_en rises, conv_valid stays low for two cycles and goes high in the third, unless the core goes back to sleep first.
- R5: Register contents are kept unchanged through every sleep, standby and static-shutdown period.
- R6: With internal timing and an automatic code, a conv_done pulse puts the core to sleep in the next cycle. The core wakes one cycle after a convert-start fall, or after a chip-select rise that follows a sw_cnv pulse. A chip-select rise with no sw_cnv pending leaves the core asleep.
- R7: Static code 01 or 11 forces core_en and bias_en low. Static code 10 forces core_en low and bias_en high. Either one overrides the power code. Writing static code 00 wakes the core one cycle after the write takes effect, with the full warm-up.
- R8: avg_active is high only when averaging is enabled and internal timing is selected. With external timing the averaging bit has no effect.
- R9: Reset loads power code 00, static code 00, external timing and averaging off. The core is awake and in warm-up, so conv_valid first rises in the third cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe for a received word |
| rx_word | input | 16 | Received serial word |
| cs_n | input | 1 | Chip-select, active low, synchronous to clk |
| cnvst_n | input | 1 | Convert-start, active low, synchronous to clk |
| sw_cnv | input | 1 | Software-convert request pulse |
| conv_done | input | 1 | Pulse when all requested conversions have finished |
| core_en | output | 1 | Converter core power enable |
| bias_en | output | 1 | Bias generator power enable |
| conv_valid | output | 1 | Conversions count as valid |
| avg_active | output | 1 | Averaging in effect |

## Verification
An event seen at a clock edge (an input edge, a done pulse or a word strobe) changes core_en and bias_en in the cycle right after that edge. conv_valid follows in the third cycle, and a cleared static shutdown wakes the core one cycle later than the other wake events. The bench drives its inputs on the falling clock edge and updates a behavioural model on the rising edge. It compares the model with the outputs on every falling edge, and the directed checks sample at the same cycle offsets.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL   = 2'b00,
        PM_AUTO_OFF = 2'b01,
        PM_STANDBY  = 2'b10,
        PM_SPARE    = 2'b11
    } pm_mode_e;

    typedef enum logic [1:0] {
        SD_NONE    = 2'b00,
        SD_FULL    = 2'b01,
        SD_PARTIAL = 2'b10,
        SD_FULL2   = 2'b11
    } static_sd_e;

    typedef struct packed {
        pm_mode_e   pm;
        logic       int_clk;
        logic       avg_on;
        static_sd_e sd;
    } pwr_cfg_t;

endpackage

// File: rtl/adc_pwr_regs.sv
module adc_pwr_regs
    import adc_pwr_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int MODE_PM_LSB  = 4,
    parameter int MODE_CLK_BIT = 6,
    parameter int CFG_AVG_BIT  = 9,
    parameter int CFG_SD_LSB   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output pwr_cfg_t          cfg_q,
    output logic              mode_wr,
    output logic              cfg_wr
);
    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] CFG_SEL = 5'b10000;
    localparam logic [WORD_W-1:0] USED_MASK =
        ({WORD_W{1'b1}} << (WORD_W - SEL_W))
        | (WORD_W'(3) << MODE_PM_LSB)
        | (WORD_W'(1) << MODE_CLK_BIT)
        | (WORD_W'(1) << CFG_AVG_BIT)
        | (WORD_W'(3) << CFG_SD_LSB);

    pwr_cfg_t cfg_d;
    logic     unused_bits;

    assign unused_bits = ^(rx_word & ~USED_MASK);
    assign mode_wr = rx_valid && !rx_word[WORD_W-1];
    assign cfg_wr  = rx_valid && (rx_word[WORD_W-1 -: SEL_W] == CFG_SEL);

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) begin
            cfg_d.pm      = pm_mode_e'(rx_word[MODE_PM_LSB +: 2]);
            cfg_d.int_clk = rx_word[MODE_CLK_BIT];
        end
        if (cfg_wr) begin
            cfg_d.avg_on = rx_word[CFG_AVG_BIT];
            cfg_d.sd     = static_sd_e'(rx_word[CFG_SD_LSB +: 2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{pm: PM_NORMAL, int_clk: 1'b0, avg_on: 1'b0, sd: SD_NONE};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R5: no strobe, no change to any stored field
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(cfg_q));

    // R1: a word with bit 15 set but the wrong selector leaves everything alone
    p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_word[WORD_W-1] && rx_word[WORD_W-1 -: SEL_W] != CFG_SEL)
        |=> $stable(cfg_q));

endmodule

// File: rtl/adc_pwr_edges.sv
module adc_pwr_edges #(
    parameter int             N    = 2,
    parameter logic [N-1:0]   IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] sig_d, sig_q;

    always_comb sig_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= IDLE;
        else        sig_q <= sig_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = sig[i] & ~sig_q[i];
        assign fall[i] = ~sig[i] & sig_q[i];
    end

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int WARM_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pwr_cfg_t cfg,
    input  logic     mode_wr,
    input  logic     cfg_wr,
    input  logic     cs_rise,
    input  logic     cs_fall,
    input  logic     cnv_fall,
    input  logic     sw_cnv,
    input  logic     conv_done,
    output logic     core_en,
    output logic     bias_en,
    output logic     conv_valid
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] WARM_LOAD = CW'(WARM_CYCLES);

    typedef struct packed {
        logic          awake;
        logic [CW-1:0] warm;
        logic          armed;
        logic          sw_arm;
        logic          sd_prev;
    } seq_t;

    seq_t st_d, st_q;
    logic auto_m, ext_m, sd_on, sleep_ev, wake_ev;

    always_comb begin
        auto_m   = (cfg.pm == PM_AUTO_OFF) || (cfg.pm == PM_STANDBY);
        ext_m    = !cfg.int_clk;
        sd_on    = (cfg.sd != SD_NONE);
        sleep_ev = auto_m && ((ext_m && cs_rise && st_q.armed) || (!ext_m && conv_done));
        wake_ev  = !auto_m || (ext_m && cs_fall)
                 || (!ext_m && (cnv_fall || (cs_rise && st_q.sw_arm)));

        st_d = st_q;
        st_d.sd_prev = sd_on;
        if (st_q.awake && st_q.warm != '0) st_d.warm = st_q.warm - 1'b1;
        if (cs_fall && auto_m && ext_m) st_d.armed = 1'b1;
        if (mode_wr) st_d.armed = 1'b0;

        if (sd_on) begin
            st_d.awake = 1'b0;
            st_d.warm  = WARM_LOAD;
        end else if (st_q.sd_prev || (!st_q.awake && wake_ev)) begin
            st_d.awake  = 1'b1;
            st_d.warm   = WARM_LOAD;
            st_d.sw_arm = 1'b0;
        end else if (st_q.awake && sleep_ev) begin
            st_d.awake = 1'b0;
        end

        if (sw_cnv) st_d.sw_arm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{awake: 1'b1, warm: WARM_LOAD, armed: 1'b0, sw_arm: 1'b0, sd_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign core_en    = st_q.awake && !sd_on;
    assign bias_en    = (cfg.sd == SD_PARTIAL)
                      || (!sd_on && (st_q.awake || cfg.pm == PM_STANDBY));
    assign conv_valid = core_en && (st_q.warm == '0);

    // R4: the first two cycles after a wake are blanked
    p_blank_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> !conv_valid);
    p_blank_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |=> !conv_valid);

    // R3: a frame opening wakes a sleeping core in external timing
    p_ext_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.awake && ext_m && auto_m && cs_fall && !sd_on && !st_q.sd_prev && !cfg_wr)
        |=> (core_en && !conv_valid));

    // R6: completion puts an awake core to sleep in internal timing
    p_int_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.awake && !ext_m && auto_m && conv_done && !sd_on && !st_q.sd_prev && !cfg_wr)
        |=> !core_en);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int WARM_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              cs_n,
    input  logic              cnvst_n,
    input  logic              sw_cnv,
    input  logic              conv_done,
    output logic              core_en,
    output logic              bias_en,
    output logic              conv_valid,
    output logic              avg_active
);
    localparam int NEDGE = 2;

    pwr_cfg_t         cfg_q;
    logic             mode_wr, cfg_wr;
    logic [NEDGE-1:0] rise_v, fall_v;

    adc_pwr_regs #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .cfg_q    (cfg_q),
        .mode_wr  (mode_wr),
        .cfg_wr   (cfg_wr)
    );

    adc_pwr_edges #(.N(NEDGE), .IDLE(2'b11)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({cnvst_n, cs_n}),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    adc_pwr_fsm #(.WARM_CYCLES(WARM_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .mode_wr    (mode_wr),
        .cfg_wr     (cfg_wr),
        .cs_rise    (rise_v[0]),
        .cs_fall    (fall_v[0]),
        .cnv_fall   (fall_v[1]),
        .sw_cnv     (sw_cnv),
        .conv_done  (conv_done),
        .core_en    (core_en),
        .bias_en    (bias_en),
        .conv_valid (conv_valid)
    );

    assign avg_active = cfg_q.avg_on && cfg_q.int_clk;

    // R8: averaging can only come into effect through a register write
    p_avg_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_active) |-> $past(rx_valid));

endmodule

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_word = '0;
    logic        cs_n = 1'b1, cnvst_n = 1'b1, sw_cnv = 1'b0, conv_done = 1'b0;
    logic        core_en, bias_en, conv_valid, avg_active;

    int    checks = 0, failures = 0;
    bit    finished = 1'b0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    adc_pwr_seq dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
        .cs_n(cs_n), .cnvst_n(cnvst_n), .sw_cnv(sw_cnv), .conv_done(conv_done),
        .core_en(core_en), .bias_en(bias_en), .conv_valid(conv_valid),
        .avg_active(avg_active)
    );

    // behavioural reference
    int m_pm, m_sd, m_warm;
    bit m_int, m_avg, m_awake, m_armed, m_sw, m_sdprev, m_pcs, m_pcnv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pm = 0; m_sd = 0; m_int = 0; m_avg = 0;
            m_awake = 1; m_warm = 2; m_armed = 0; m_sw = 0; m_sdprev = 0;
            m_pcs = 1; m_pcnv = 1;
        end else begin
            bit is_auto, is_ext, sd_active, csf, csr, cnf, go_sleep, go_wake;
            is_auto   = (m_pm == 1 || m_pm == 2);
            is_ext    = !m_int;
            sd_active = (m_sd != 0);
            csf = m_pcs && !cs_n;
            csr = !m_pcs && cs_n;
            cnf = m_pcnv && !cnvst_n;
            go_sleep = is_auto && (is_ext ? (csr && m_armed) : conv_done);
            go_wake  = !is_auto || (is_ext ? csf : (cnf || (csr && m_sw)));
            if (m_awake && m_warm > 0) m_warm--;
            if (csf && is_auto && is_ext) m_armed = 1;
            if (rx_valid && !rx_word[15]) m_armed = 0;
            if (sd_active) begin
                m_awake = 0; m_warm = 2;
            end else if (m_sdprev || (!m_awake && go_wake)) begin
                m_awake = 1; m_warm = 2; m_sw = 0;
            end else if (m_awake && go_sleep) begin
                m_awake = 0;
            end
            if (sw_cnv) m_sw = 1;
            m_sdprev = sd_active;
            if (rx_valid && !rx_word[15]) begin
                m_pm = int'(rx_word[5:4]); m_int = rx_word[6];
            end
            if (rx_valid && rx_word[15:11] == 5'b10000) begin
                m_avg = rx_word[9]; m_sd = int'(rx_word[1:0]);
            end
            m_pcs = cs_n; m_pcnv = cnvst_n;
        end
    end

    function automatic bit exp_core(); return m_awake && m_sd == 0; endfunction
    function automatic bit exp_bias();
        if (m_sd == 2) return 1;
        if (m_sd != 0) return 0;
        return m_awake || m_pm == 2;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !finished) begin
        chk(cur_req, "model core_en", core_en, exp_core());
        chk(cur_req, "model bias_en", bias_en, exp_bias());
        chk(cur_req, "model conv_valid", conv_valid, exp_core() && m_warm == 0);
        chk(cur_req, "model avg_active", avg_active, m_avg && m_int);
    end

    task automatic step(int n); repeat (n) @(negedge clk); endtask
    task automatic wr(logic [15:0] w);
        @(negedge clk); rx_valid = 1'b1; rx_word = w;
        @(negedge clk); rx_valid = 1'b0;
    endtask
    task automatic pulse_done();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask
    task automatic pulse_sw();
        @(negedge clk); sw_cnv = 1'b1;
        @(negedge clk); sw_cnv = 1'b0;
    endtask
    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        report();
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R9", "core_en after reset", core_en, 1'b1);
        chk("R9", "bias_en after reset", bias_en, 1'b1);
        chk("R9", "valid blanked after reset", conv_valid, 1'b0);
        chk("R9", "avg off after reset", avg_active, 1'b0);
        step(2);
        chk("R9", "valid in third cycle", conv_valid, 1'b1);

        // external timing, auto-shutdown
        cur_req = "R3";
        cs_n = 1'b0; step(1);
        wr(16'h0010);
        cs_n = 1'b1; step(2);
        chk("R3", "no sleep in write frame", core_en, 1'b1);
        cs_n = 1'b0; step(2);
        cs_n = 1'b1; step(1);
        chk("R3", "sleep on frame end", core_en, 1'b0);
        chk("R2", "auto-shutdown bias off", bias_en, 1'b0);
        step(3);
        chk("R3", "still asleep", core_en, 1'b0);
        cur_req = "R4";
        cs_n = 1'b0; step(1);
        chk("R3", "wake on frame open", core_en, 1'b1);
        chk("R4", "blank cycle 1", conv_valid, 1'b0);
        step(1);
        chk("R4", "blank cycle 2", conv_valid, 1'b0);
        step(1);
        chk("R4", "valid cycle 3", conv_valid, 1'b1);

        // auto-standby
        cur_req = "R2";
        wr(16'h0020);
        cs_n = 1'b1; step(2);
        cs_n = 1'b0; step(2);
        cs_n = 1'b1; step(1);
        chk("R2", "standby core off", core_en, 1'b0);
        chk("R2", "standby bias on", bias_en, 1'b1);
        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            cs_n = 1'b0; step(3);
            chk("R5", "mode kept, wakes", core_en, 1'b1);
            cs_n = 1'b1; step(1);
            chk("R5", "mode kept, standby bias", bias_en, 1'b1);
        end

        // spare code acts as normal
        cur_req = "R2";
        cs_n = 1'b0; step(2);
        wr(16'h0030);
        cs_n = 1'b1; step(2);
        cs_n = 1'b0; step(2);
        cs_n = 1'b1; step(2);
        chk("R2", "code 11 stays awake", core_en, 1'b1);

        // ignored word and averaging in external timing
        cur_req = "R1";
        wr(16'h9201);
        step(1);
        chk("R1", "foreign word no static", core_en, 1'b1);
        chk("R1", "foreign word no avg", avg_active, 1'b0);
        cur_req = "R8";
        wr(16'h8200);
        step(1);
        chk("R8", "avg ignored in external", avg_active, 1'b0);

        // static shutdown
        cur_req = "R7";
        wr(16'h8001); step(1);
        chk("R7", "full core off", core_en, 1'b0);
        chk("R7", "full bias off", bias_en, 1'b0);
        cs_n = 1'b0; step(2);
        chk("R7", "frame open ignored", core_en, 1'b0);
        cs_n = 1'b1;
        wr(16'h8002); step(1);
        chk("R7", "partial core off", core_en, 1'b0);
        chk("R7", "partial bias on", bias_en, 1'b1);
        wr(16'h8000);
        chk("R7", "still off on clear cycle", core_en, 1'b0);
        step(1);
        chk("R7", "wake after clear", core_en, 1'b1);
        chk("R7", "warm-up after clear", conv_valid, 1'b0);
        step(2);
        chk("R7", "valid after clear", conv_valid, 1'b1);

        // internal timing, auto-shutdown
        cur_req = "R6";
        wr(16'h0050);
        wr(16'h8200); step(1);
        chk("R8", "avg active in internal", avg_active, 1'b1);
        pulse_done();
        chk("R6", "sleep on done", core_en, 1'b0);
        cs_n = 1'b0; step(1);
        cs_n = 1'b1; step(1);
        chk("R6", "cs rise without sw ignored", core_en, 1'b0);
        cnvst_n = 1'b0; step(1);
        chk("R6", "wake on convert start", core_en, 1'b1);
        cnvst_n = 1'b1; step(3);
        pulse_done();
        chk("R6", "sleep again", core_en, 1'b0);
        pulse_sw();
        cs_n = 1'b0; step(1);
        cs_n = 1'b1; step(1);
        chk("R6", "wake on cs after sw", core_en, 1'b1);
        step(3);
        pulse_done();
        cs_n = 1'b0; step(1);
        cs_n = 1'b1; step(1);
        chk("R6", "sw request consumed", core_en, 1'b0);
        wr(16'h0040); step(1);
        chk("R2", "normal write wakes", core_en, 1'b1);
        step(3);

        finished = 1'b1;
        report();
    end
endmodule